// File: doc/BRIEF.md
# Half-Cycle Generator Trigger Sequencer

This block fires the half-cycle generator modules of a pulsed 100 kHz transmitter. Each pulse is built from four drive half cycles, and every half-cycle window lasts `WIN_CYCLES` clocks (5 µs at the design clock). When the station timer sends a trigger, the block loads a new module assignment and runs the four windows. In each window it fires a programmable number of healthy modules that are assigned to that window. Modules flagged as failed are passed over, and the next healthy module assigned to the same window takes their place.

The modules are split into groups of `GRP_SIZE`. Each group has its own serial trigger stream and a frame strobe. The carrier polarity for phase coding comes from set and reset pulses and is captured once per pulse. Configuration is written one entry at a time into a shadow table, and the shadow table is copied into the active table only when a pulse starts. Three conditions blank the trigger streams: a failsafe request, backup mode, or a request for more modules than are healthy.

Top module: `hcg_trigger_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`, `cfg_err_o`, `pol_o`, every `ser_o` bit and every `frm_o` bit are 0.
- R2: If `trig_i` is high while idle, a pulse starts and `busy_o` stays high for exactly 4·`WIN_CYCLES` cycles. A `trig_i` that arrives while busy is ignored and does not lengthen or restart the pulse.
- R3: Each of the four windows starts with `frm_o[g]` high for exactly one cycle on every group. In cycle c of a window, for c < `GRP_SIZE`, `ser_o[g]` carries bit `GRP_SIZE-1-c` of that group's fire mask, so the most significant bit comes first. Bit i stands for module g·`GRP_SIZE`+i. The remaining cycles of the window are 0, and both outputs are 0 while idle.
- R4: Window h (0..3, in time order) fires the first `cnt_i[h]` modules that are healthy and assigned to slot h, taken in ascending module index. No other module fires in that window. The count for window h sits in `cnt_i[h*CW +: CW]`.
- R5: A module whose `fail_i` bit is set when the pulse is triggered never fires in that pulse. Healthy spares assigned to the same slot fill its place.
- R6: A table write (`wr_used_i` = 1 makes the module assigned, `wr_slot_i` gives its window) changes only the shadow table. The new entry takes effect at the next accepted trigger. A write made during a pulse does not alter that pulse.
- R7: A `pol_pos_i` pulse selects positive polarity (1) and a `pol_neg_i` pulse selects negative polarity (0). If both are high in the same cycle, positive wins. `pol_o` shows the polarity held at the accepted trigger and keeps it until the next accepted trigger.
- R8: If `failsafe_i` is high at the accepting trigger edge, or at any edge during the pulse, all `ser_o` and `frm_o` are 0 from then until the pulse ends.
- R9: While `backup_i` is high, `ser_o`, `frm_o` and `pol_o` are 0 in the same cycle.
- R10: If the four counts add up to more than the number of assigned healthy modules, that pulse is fully blanked. In addition, `cfg_err_o` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Pulse trigger from the station timer |
| pol_pos_i | input | 1 | Phase-code pulse selecting positive polarity |
| pol_neg_i | input | 1 | Phase-code pulse selecting negative polarity |
| failsafe_i | input | 1 | Failsafe blanking request |
| backup_i | input | 1 | Backup mode; holds the outputs inactive |
| fail_i | input | NUM_HCG | Per-module failed flags |
| cnt_i | input | 4·CW | Modules to fire per window; window h at [h·CW +: CW] |
| wr_en_i | input | 1 | Shadow table write strobe |
| wr_idx_i | input | IW | Module index to write |
| wr_used_i | input | 1 | Module is assigned |
| wr_slot_i | input | 2 | Window assigned to the module |
| ser_o | output | N_GROUPS | Serial trigger stream per group |
| frm_o | output | N_GROUPS | Frame strobe per group, high on the first bit |
| pol_o | output | 1 | Carrier polarity of the current pulse |
| busy_o | output | 1 | Pulse in progress |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
A fault in the active table or in the selection logic shows up as a wrong serial word within 12 cycles of that window's frame strobe. Because the bench compares every window of every group, a single wrongly chosen module is caught in the pulse where it occurs. A window counter that is off would move a strobe or change the pulse length, and this is caught at the first pulse. A polarity, blanking or error register that latches at the wrong time is seen on `pol_o`, on a blanked stream or on `cfg_err_o` by the end of the affected pulse.

// File: rtl/hcg_seq_pkg.sv
package hcg_seq_pkg;
    localparam int HALVES = 4;
    localparam int SLOT_W = 2;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic  used;
        slot_t slot;
    } asg_t;

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } pol_t;

    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/hcg_asg_table.sv
module hcg_asg_table
    import hcg_seq_pkg::*;
#(
    parameter int NUM_HCG = 48,
    localparam int IW = $clog2(NUM_HCG)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_idx,
    input  asg_t                    wr_data,
    input  logic                    swap,
    output asg_t [NUM_HCG-1:0]      act_o
);
    asg_t [NUM_HCG-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            act_o    <= '0;
        end else begin
            if (wr_en && (int'(wr_idx) < NUM_HCG))
                shadow_q[wr_idx] <= wr_data;
            if (swap)
                act_o <= shadow_q;
        end
    end

    AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !swap |=> $stable(act_o)); // R6
endmodule

// File: rtl/hcg_fire_select.sv
module hcg_fire_select
    import hcg_seq_pkg::*;
#(
    parameter int NUM_HCG = 48,
    localparam int CW = cnt_width(NUM_HCG)
) (
    input  asg_t [NUM_HCG-1:0]               act,
    input  logic [NUM_HCG-1:0]               fail,
    input  logic [HALVES-1:0][CW-1:0]        cnt,
    output logic [HALVES-1:0][NUM_HCG-1:0]   fire,
    output logic                             over
);
    always_comb begin
        logic [CW-1:0] run;
        logic          elig;
        fire = '0;
        for (int h = 0; h < HALVES; h++) begin
            run = '0;
            for (int i = 0; i < NUM_HCG; i++) begin
                elig = act[i].used && (act[i].slot == slot_t'(h)) && !fail[i];
                fire[h][i] = elig && (run < cnt[h]);
                if (elig) run = run + 1'b1;
            end
        end
    end

    always_comb begin
        logic [CW-1:0]   healthy;
        logic [CW+1:0]   total;
        healthy = '0;
        total   = '0;
        for (int i = 0; i < NUM_HCG; i++)
            if (act[i].used && !fail[i]) healthy = healthy + 1'b1;
        for (int h = 0; h < HALVES; h++)
            total = total + {2'b00, cnt[h]};
        over = total > {2'b00, healthy};
    end
endmodule

// File: rtl/hcg_win_timer.sv
module hcg_win_timer
    import hcg_seq_pkg::*;
#(
    parameter int WIN_CYCLES = 500,
    localparam int CYW = $clog2(WIN_CYCLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    output logic              busy,
    output logic [SLOT_W-1:0] win,
    output logic [CYW-1:0]    cyc
);
    logic last_cyc;
    assign last_cyc = (cyc == CYW'(WIN_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            win  <= '0;
            cyc  <= '0;
        end else if (!busy) begin
            if (go) begin
                busy <= 1'b1;
                win  <= '0;
                cyc  <= '0;
            end
        end else if (last_cyc) begin
            cyc <= '0;
            if (win == SLOT_W'(HALVES - 1)) busy <= 1'b0;
            else                            win  <= win + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !(last_cyc && win == SLOT_W'(HALVES - 1))) |=> busy); // R2
endmodule

// File: rtl/hcg_trigger_seq.sv
module hcg_trigger_seq
    import hcg_seq_pkg::*;
#(
    parameter int N_GROUPS   = 4,
    parameter int GRP_SIZE   = 12,
    parameter int WIN_CYCLES = 500,
    localparam int NUM_HCG = N_GROUPS * GRP_SIZE,
    localparam int IW      = $clog2(NUM_HCG),
    localparam int CW      = cnt_width(NUM_HCG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   trig_i,
    input  logic                   pol_pos_i,
    input  logic                   pol_neg_i,
    input  logic                   failsafe_i,
    input  logic                   backup_i,
    input  logic [NUM_HCG-1:0]     fail_i,
    input  logic [HALVES*CW-1:0]   cnt_i,
    input  logic                   wr_en_i,
    input  logic [IW-1:0]          wr_idx_i,
    input  logic                   wr_used_i,
    input  logic [SLOT_W-1:0]      wr_slot_i,
    output logic [N_GROUPS-1:0]    ser_o,
    output logic [N_GROUPS-1:0]    frm_o,
    output logic                   pol_o,
    output logic                   busy_o,
    output logic                   cfg_err_o
);
    localparam int CYW = $clog2(WIN_CYCLES);
    localparam int BW  = $clog2(GRP_SIZE);

    logic                            busy;
    logic [SLOT_W-1:0]               win;
    logic [CYW-1:0]                  cyc;
    logic                            accept;
    asg_t [NUM_HCG-1:0]              act;
    logic [NUM_HCG-1:0]              fail_q;
    logic [HALVES-1:0][CW-1:0]       cnt_q;
    logic [HALVES-1:0][NUM_HCG-1:0]  fire;
    logic                            over;
    pol_t                            pol_state, pol_cap;
    logic                            blank_q, err_q, live;

    assign accept = trig_i && !busy;

    hcg_asg_table #(.NUM_HCG(NUM_HCG)) u_table (
        .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_idx(wr_idx_i),
        .wr_data('{used: wr_used_i, slot: wr_slot_i}),
        .swap(accept), .act_o(act)
    );

    hcg_fire_select #(.NUM_HCG(NUM_HCG)) u_select (
        .act(act), .fail(fail_q), .cnt(cnt_q), .fire(fire), .over(over)
    );

    hcg_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(accept), .busy(busy), .win(win), .cyc(cyc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q    <= '0;
            cnt_q     <= '0;
            pol_state <= POL_NEG;
            pol_cap   <= POL_NEG;
            blank_q   <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (pol_pos_i)      pol_state <= POL_POS;
            else if (pol_neg_i) pol_state <= POL_NEG;
            if (accept) begin
                fail_q  <= fail_i;
                cnt_q   <= cnt_i;
                pol_cap <= pol_state;
                blank_q <= failsafe_i;
            end else if (busy && failsafe_i) begin
                blank_q <= 1'b1;
            end
            if (busy && over) err_q <= 1'b1;
        end
    end

    assign live      = busy && !blank_q && !over && !backup_i;
    assign pol_o     = (pol_cap == POL_POS) && !backup_i;
    assign busy_o    = busy;
    assign cfg_err_o = err_q;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic [GRP_SIZE-1:0] bits;
        logic [BW-1:0]       idx;
        logic                bit_now;
        assign bits    = fire[win][g*GRP_SIZE +: GRP_SIZE];
        assign idx     = BW'(GRP_SIZE - 1) - BW'(cyc);
        assign bit_now = (int'(cyc) < GRP_SIZE) ? bits[idx] : 1'b0;
        assign ser_o[g] = live && bit_now;
        assign frm_o[g] = live && (cyc == '0);
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_chk
        AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (rst)
            busy |-> ($countones(fire[h]) <= int'(cnt_q[h]))); // R4
        AST_FIRE_HEALTHY: assert property (@(posedge clk) disable iff (rst)
            busy |-> ((fire[h] & fail_q) == '0)); // R5
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (ser_o == '0 && frm_o == '0)); // R3
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(pol_cap)); // R7
    AST_FAILSAFE_BLANK: assert property (@(posedge clk) disable iff (rst)
        ($past(failsafe_i) && busy_o) |-> (ser_o == '0 && frm_o == '0)); // R8
    AST_BACKUP_HOLD: assert property (@(posedge clk) disable iff (rst)
        backup_i |-> (ser_o == '0 && frm_o == '0 && !pol_o)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |=> cfg_err_o); // R10
endmodule

// File: tb/hcg_trigger_seq_test.sv
module hcg_trigger_seq_test;
    localparam int NG = 4, GS = 12, WIN = 16, NH = NG * GS, CW = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, trig = 1'b0, pol_pos = 1'b0, pol_neg = 1'b0;
    logic failsafe = 1'b0, backup = 1'b0, wr_en = 1'b0, wr_used = 1'b0;
    logic [NH-1:0] fail = '0;
    logic [4*CW-1:0] cnt = '0;
    logic [5:0] wr_idx = '0;
    logic [1:0] wr_slot = '0;
    logic [NG-1:0] ser, frm;
    logic pol, busy, cerr;

    hcg_trigger_seq #(.N_GROUPS(NG), .GRP_SIZE(GS), .WIN_CYCLES(WIN)) uut (
        .clk(clk), .rst(rst), .trig_i(trig), .pol_pos_i(pol_pos), .pol_neg_i(pol_neg),
        .failsafe_i(failsafe), .backup_i(backup), .fail_i(fail), .cnt_i(cnt),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_used_i(wr_used), .wr_slot_i(wr_slot),
        .ser_o(ser), .frm_o(frm), .pol_o(pol), .busy_o(busy), .cfg_err_o(cerr)
    );

    int nchk = 0, nbad = 0;
    bit done = 1'b0, errm = 1'b0;
    int m_used[NH], m_slot[NH], a_used[NH], a_slot[NH], cntm[4];

    task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    task automatic wr(input int idx, input int u, input int s);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_used = u[0]; wr_slot = 2'(s);
        m_used[idx] = u; m_slot[idx] = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cnt(input int c0, input int c1, input int c2, input int c3);
        cntm[0] = c0; cntm[1] = c1; cntm[2] = c2; cntm[3] = c3;
        for (int h = 0; h < 4; h++) cnt[h*CW +: CW] = CW'(cntm[h]);
    endtask

    task automatic set_pol(input bit p);
        @(negedge clk);
        if (p) pol_pos = 1'b1; else pol_neg = 1'b1;
        @(negedge clk);
        pol_pos = 1'b0; pol_neg = 1'b0;
    endtask

    // mid: 0 none, 1 extra trigger mid-pulse, 2 shadow write mid-pulse
    task automatic run_pulse(input bit fs, input bit bk, input int mid, input bit pol_exp);
        logic [NH-1:0] ef[4];
        logic [WIN-1:0] sser[4][NG], sfrm[4][NG], eser, efrm;
        int run, healthy, total;
        bit over, blank, busy_ok, pol_ok;
        string tag;
        for (int i = 0; i < NH; i++) begin a_used[i] = m_used[i]; a_slot[i] = m_slot[i]; end
        healthy = 0; total = 0;
        for (int i = 0; i < NH; i++) if (a_used[i] != 0 && !fail[i]) healthy++;
        for (int h = 0; h < 4; h++) begin
            total += cntm[h];
            ef[h] = '0; run = 0;
            for (int i = 0; i < NH; i++)
                if (a_used[i] != 0 && a_slot[i] == h && !fail[i]) begin
                    if (run < cntm[h]) ef[h][i] = 1'b1;
                    run++;
                end
        end
        over = total > healthy;
        errm = errm | over;
        blank = fs | bk | over;
        tag = over ? "R10" : fs ? "R8" : bk ? "R9" : (mid == 2) ? "R6" : "R4";

        @(negedge clk);
        trig = 1'b1; failsafe = fs; backup = bk;
        @(negedge clk);
        trig = 1'b0; failsafe = 1'b0;
        busy_ok = 1'b1; pol_ok = 1'b1;
        for (int w = 0; w < 4; w++)
            for (int c = 0; c < WIN; c++) begin
                if (busy !== 1'b1) busy_ok = 1'b0;
                if (pol !== (pol_exp & ~bk)) pol_ok = 1'b0;
                for (int g = 0; g < NG; g++) begin
                    sser[w][g][WIN-1-c] = ser[g];
                    sfrm[w][g][WIN-1-c] = frm[g];
                end
                if (w == 1 && c == 3) begin
                    if (mid == 1) trig = 1'b1;
                    if (mid == 2) begin
                        wr_en = 1'b1; wr_idx = 6'd0; wr_used = 1'b0;
                        m_used[0] = 0;
                    end
                end
                if (w == 1 && c == 4) begin trig = 1'b0; wr_en = 1'b0; end
                @(negedge clk);
            end
        backup = 1'b0;
        chk(busy_ok && busy === 1'b0, "R2 pulse length", {busy_ok, busy}, 2'b10);
        chk(pol_ok, bk ? "R9 polarity held low" : "R7 polarity", pol, pol_exp & ~bk);
        for (int w = 0; w < 4; w++)
            for (int g = 0; g < NG; g++) begin
                eser = '0; efrm = '0;
                if (!blank) begin
                    efrm[WIN-1] = 1'b1;
                    for (int c = 0; c < GS; c++) eser[WIN-1-c] = ef[w][g*GS + GS-1-c];
                end
                chk(sser[w][g] === eser && sfrm[w][g] === efrm,
                    $sformatf("%s/R3 window %0d group %0d", tag, w, g),
                    {sfrm[w][g], sser[w][g]}, {efrm, eser});
            end
        chk(cerr === errm, "R10 sticky error flag", cerr, errm);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NH; i++) begin m_used[i] = 0; m_slot[i] = 0; end
        set_cnt(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy === 0 && cerr === 0 && pol === 0 && ser === '0 && frm === '0,
            "R1 reset state", {busy, cerr, pol, ser, frm}, 0);

        // 2-2-6-6 split on modules 0..15
        for (int i = 0; i < 16; i++) wr(i, 1, (i < 2) ? 0 : (i < 4) ? 1 : (i < 10) ? 2 : 3);
        set_cnt(2, 2, 6, 6);
        run_pulse(0, 0, 0, 0);

        // 4-4-4-4 with spares and failed modules (R5), positive polarity
        for (int i = 16; i < 24; i++) wr(i, 1, (i < 20) ? 0 : 1);
        fail = '0; fail[0] = 1'b1; fail[4] = 1'b1; fail[5] = 1'b1;
        set_cnt(4, 4, 4, 4);
        set_pol(1);
        run_pulse(0, 0, 0, 1);

        // sweep over full table, counts and failure patterns
        for (int i = 0; i < NH; i++) wr(i, 1, i % 4);
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < NH; i++) fail[i] = ((i * 7 + k) % 11) == 0;
            set_cnt(k % 9, (k + 3) % 9, (k + 6) % 9, (k + 9) % 9);
            set_pol(k[0]);
            run_pulse(0, 0, 0, k[0]);
        end

        // R6 shadow write mid-pulse, then effect on next pulse
        fail = '0;
        set_cnt(3, 3, 3, 3);
        run_pulse(0, 0, 2, 1);
        run_pulse(0, 0, 0, 1);

        // R2 extra trigger during a pulse
        set_pol(0);
        run_pulse(0, 0, 1, 0);

        // R8 failsafe, R9 backup
        run_pulse(1, 0, 0, 0);
        set_pol(1);
        run_pulse(0, 1, 0, 1);
        run_pulse(0, 0, 0, 1);

        // R10 overcommitted counts, then a normal pulse with error still held
        for (int i = 0; i < 8; i++) fail[i] = 1'b1;
        set_cnt(12, 12, 12, 12);
        run_pulse(0, 0, 0, 1);
        set_cnt(2, 5, 1, 7);
        run_pulse(0, 0, 0, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end
endmodule